// File: doc/BRIEF.md
# Byte-Addressed Converter Bus Target

This block is the device side of an asynchronous parallel bus for a converter. It shows a 12-bit conversion result to the host and takes a 16-bit control word from the host. Chip select, read strobe and write strobe are active-low and have no timing relation to the system clock. They are brought into the clock domain by a synchronizer. A single byte-select line does two jobs. On a read it picks either the full result or the upper byte of the 16-bit result word. On a write it picks which half of the incoming word is being transferred.

A write arrives as two bytes. The first byte, sent with byte-select low, is held. The second byte, sent with byte-select high, completes the word, and the block stores it in one of two registers chosen by the word's top bits. One register is the control register. The other is a test register whose default value can be put back by writing that value again. The conversion engine is not part of this block. In its place, a result and a valid pulse are loaded during a busy period. The new result reaches the bus only when busy ends. A delayed busy output lets a host that keeps chip select and read strobe low all the time use the falling busy edge to latch the data.

Top module: `conv_bus_target`

## Requirements
- R1: After reset the data-line enables are all 0, the control register reads 0x0000, the test register reads 0x4002 and the busy output is 0.
- R2: With chip select and read strobe both low and byte-select low, all 12 data lines are enabled and carry the result, bit 0 on line 0.
- R3: With chip select and read strobe both low and byte-select high, lines 0 to 7 are enabled and carry bits 15:8 of the 16-bit result word. That word is four zero bits above the 12-bit result. Lines 8 to 11 are not enabled and read 0.
- R4: The data lines are enabled only while chip select and read strobe are both low. After either one goes high, all enables return to 0 within 16 clock cycles. If only one of the two strobes is low, no line is enabled.
- R5: A write with byte-select low holds the byte on lines 0 to 7 and changes no register. A write with byte-select high forms the word {high byte, held low byte}. Write data comes from lines 0 to 7 only.
- R6: A completed word whose bits 15:14 equal 2'b01 goes to the test register. Any other completed word goes to the control register. A completed write changes only one register.
- R7: A register changes only when the write access ends, that is, when chip select and write strobe stop being low together. It stays unchanged while the strobe is still low.
- R8: A result loaded while busy is high does not appear on the data lines until the busy input falls. The result shown before that point is kept.
- R9: The busy output follows the busy input three clock cycles later. When the busy output falls, the new result is already on the continuously driven data lines.
- R10: Writing 0x4002 as two bytes returns the test register to its default value after any other value has been written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| rd_ni | input | 1 | Read strobe, active low, asynchronous |
| wr_ni | input | 1 | Write strobe, active low, asynchronous |
| hb_sel_i | input | 1 | Byte-select: upper byte or half when high |
| data_i | input | 8 | Inbound write data on bus lines 0 to 7 |
| data_o | output | 12 | Outbound bus line values |
| data_oe_o | output | 12 | Per-line output enable, 1 means driven |
| res_i | input | 12 | Result from the conversion model |
| res_vld_i | input | 1 | Pulse that loads res_i as the pending result |
| busy_i | input | 1 | Conversion-in-progress flag from the model |
| busy_o | output | 1 | Busy flag on the bus side, lagging busy_i |
| ctrl_o | output | 16 | Control register contents |
| test_o | output | 16 | Test register contents |

## Verification
The bench builds the block with its default parameters: a 12-bit result, a 12-line bus, 8-bit bytes, a two-stage synchronizer and a release hold of two cycles. With these values, both read widths can be checked on one bus. Upper-byte reads show the zero nibble above the result. Words of 0x4xxx test the split between the two destination registers. The release window is short enough that late enables show up inside a bounded wait, and the three-cycle busy lag can be seen cycle by cycle in free-running mode.

// File: rtl/conv_bus_pkg.sv
package conv_bus_pkg;
  localparam int WORD_W = 16;
  localparam logic [1:0] TEST_SEL = 2'b01;
  localparam logic [WORD_W-1:0] TEST_DEFAULT = 16'h4002;

  typedef enum logic {DEST_CTRL = 1'b0, DEST_TEST = 1'b1} dest_e;

  function automatic dest_e dest_of(input logic [WORD_W-1:0] w);
    return (w[WORD_W-1 -: 2] == TEST_SEL) ? DEST_TEST : DEST_CTRL;
  endfunction
endpackage

// File: rtl/conv_bus_sync.sv
module conv_bus_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= RST_VAL;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s > 0) ? s-1 : 0];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/conv_bus_read.sv
module conv_bus_read
  import conv_bus_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int BUS_W = 12,
  parameter int BYTE_W = 8,
  parameter int RELEASE_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_act_i,
  input  logic             hb_sel_i,
  input  logic [RES_W-1:0] res_i,
  input  logic             res_vld_i,
  input  logic             busy_i,
  output logic [BUS_W-1:0] bus_o,
  output logic [BUS_W-1:0] oe_o,
  output logic             busy_o
);
  localparam int CNT_W = $clog2(RELEASE_CYC + 1);
  localparam int BUSY_LAG = 3;

  logic [RES_W-1:0]    pend_q, res_q;
  logic [BUSY_LAG-1:0] bdly_q;
  logic                busy_fall;
  logic [WORD_W-1:0]   word;
  logic [BUS_W-1:0]    bus_d, oe_mask;
  logic [CNT_W-1:0]    rel_cnt_q;
  logic                drive_q, hb_q;
  logic [BUS_W-1:0]    bus_q;

  assign busy_fall = bdly_q[0] & ~busy_i;
  assign word = {{(WORD_W-RES_W){1'b0}}, res_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      res_q  <= '0;
      bdly_q <= '0;
    end else begin
      bdly_q <= {bdly_q[BUSY_LAG-2:0], busy_i};
      if (res_vld_i) pend_q <= res_i;
      if (busy_fall) res_q <= res_vld_i ? res_i : pend_q;
    end
  end

  always_comb begin
    if (hb_sel_i) begin
      bus_d   = {{(BUS_W-BYTE_W){1'b0}}, word[WORD_W-1 -: BYTE_W]};
      oe_mask = {{(BUS_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
    end else begin
      bus_d   = {{(BUS_W-RES_W){1'b0}}, res_q};
      oe_mask = {BUS_W{1'b1}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drive_q   <= 1'b0;
      rel_cnt_q <= '0;
      bus_q     <= '0;
      hb_q      <= 1'b0;
    end else begin
      bus_q <= bus_d;
      hb_q  <= hb_sel_i;
      if (rd_act_i) begin
        drive_q   <= 1'b1;
        rel_cnt_q <= CNT_W'(RELEASE_CYC);
      end else if (rel_cnt_q != '0) begin
        rel_cnt_q <= rel_cnt_q - 1'b1;
      end else begin
        drive_q <= 1'b0;
      end
    end
  end

  assign bus_o  = drive_q ? (bus_q & (hb_q ? {{(BUS_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}} : {BUS_W{1'b1}})) : '0;
  assign oe_o   = drive_q ? (hb_q ? {{(BUS_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}} : {BUS_W{1'b1}}) : '0;
  assign busy_o = bdly_q[BUSY_LAG-1];

  AST_RELEASE_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drive_q) |-> $past(!rd_act_i)); // R4
  AST_HI_UPPER_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hb_q |-> (oe_o[BUS_W-1:BYTE_W] == '0)); // R3
  AST_RES_ON_BUSY_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(res_q) |-> $past(busy_fall)); // R8
  AST_DATA_BEFORE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $stable(res_q)); // R9
endmodule

// File: rtl/conv_bus_write.sv
module conv_bus_write
  import conv_bus_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_act_i,
  input  logic              hb_sel_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [WORD_W-1:0] ctrl_o,
  output logic [WORD_W-1:0] test_o
);
  logic              wr_q, hb_q, wr_end;
  logic [BYTE_W-1:0] byte_q, lo_hold_q;
  logic [WORD_W-1:0] ctrl_q, test_q, word;

  assign wr_end = wr_q & ~wr_act_i;
  assign word   = {byte_q, lo_hold_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q      <= 1'b0;
      hb_q      <= 1'b0;
      byte_q    <= '0;
      lo_hold_q <= '0;
      ctrl_q    <= '0;
      test_q    <= TEST_DEFAULT;
    end else begin
      wr_q <= wr_act_i;
      if (wr_act_i) begin
        hb_q   <= hb_sel_i;
        byte_q <= byte_i;
      end
      if (wr_end) begin
        if (!hb_q) lo_hold_q <= byte_q;
        else if (dest_of(word) == DEST_TEST) test_q <= word;
        else ctrl_q <= word;
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign test_o = test_q;

  AST_CTRL_ON_WR_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_q) |-> $past(wr_end)); // R7
  AST_TEST_ON_WR_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(test_q) |-> $past(wr_end)); // R7
  AST_ONE_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({!$stable(ctrl_q), !$stable(test_q)})); // R6
  AST_LOW_HALF_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_end && !hb_q) |=> ($stable(ctrl_q) && $stable(test_q))); // R5
endmodule

// File: rtl/conv_bus_target.sv
module conv_bus_target
  import conv_bus_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int BUS_W = 12,
  parameter int BYTE_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RELEASE_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              hb_sel_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BUS_W-1:0]  data_o,
  output logic [BUS_W-1:0]  data_oe_o,
  input  logic [RES_W-1:0]  res_i,
  input  logic              res_vld_i,
  input  logic              busy_i,
  output logic              busy_o,
  output logic [WORD_W-1:0] ctrl_o,
  output logic [WORD_W-1:0] test_o
);
  localparam int DATA_SW = BYTE_W + 1;

  logic [2:0]         strb_s;
  logic [DATA_SW-1:0] dat_s;
  logic               rd_act, wr_act;

  conv_bus_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync_strb (
    .clk_i, .rst_ni, .d_i({cs_ni, rd_ni, wr_ni}), .q_o(strb_s)
  );

  conv_bus_sync #(.W(DATA_SW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
    .clk_i, .rst_ni, .d_i({hb_sel_i, data_i}), .q_o(dat_s)
  );

  assign rd_act = ~strb_s[2] & ~strb_s[1];
  assign wr_act = ~strb_s[2] & ~strb_s[0];

  conv_bus_read #(
    .RES_W(RES_W), .BUS_W(BUS_W), .BYTE_W(BYTE_W), .RELEASE_CYC(RELEASE_CYC)
  ) u_read (
    .clk_i, .rst_ni,
    .rd_act_i (rd_act),
    .hb_sel_i (dat_s[BYTE_W]),
    .res_i, .res_vld_i, .busy_i,
    .bus_o    (data_o),
    .oe_o     (data_oe_o),
    .busy_o
  );

  conv_bus_write #(.BYTE_W(BYTE_W)) u_write (
    .clk_i, .rst_ni,
    .wr_act_i (wr_act),
    .hb_sel_i (dat_s[BYTE_W]),
    .byte_i   (dat_s[BYTE_W-1:0]),
    .ctrl_o, .test_o
  );

  AST_NO_DRIVE_IN_RESET: assert property (@(posedge clk_i)
    !rst_ni |=> (data_oe_o == '0) || rst_ni); // R1
endmodule

// File: tb/tb_conv_bus_target.sv
module tb_conv_bus_target;
  localparam time CLK_P = 5ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, hb = 1'b0;
  logic [7:0]  din = '0;
  logic [11:0] dout, doe, res = '0;
  logic res_vld = 1'b0, busy = 1'b0, busy_out;
  logic [15:0] ctrl, test;

  always #(CLK_P/2) clk = ~clk;

  conv_bus_target dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .hb_sel_i(hb), .data_i(din), .data_o(dout), .data_oe_o(doe),
    .res_i(res), .res_vld_i(res_vld), .busy_i(busy), .busy_o(busy_out),
    .ctrl_o(ctrl), .test_o(test)
  );

  typedef struct { string req; logic [31:0] exp; } item_t;
  item_t sb_q[$];
  int n_cmp = 0, n_bad = 0;

  task automatic expect_item(string req, logic [31:0] exp);
    item_t it;
    it.req = req; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic monitor_pop(logic [31:0] act);
    item_t it;
    it = sb_q.pop_front();
    n_cmp++;
    if (act !== it.exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic h, logic [7:0] b);
    hb = h; din = b; cs_n = 1'b0; wr_n = 1'b0;
    tick(5);
    cs_n = 1'b1; wr_n = 1'b1;
    tick(6);
  endtask

  task automatic load_result(logic [11:0] v);
    busy = 1'b1; tick(2);
    res = v; res_vld = 1'b1; tick(1);
    res_vld = 1'b0; tick(2);
    busy = 1'b0; tick(6);
  endtask

  task automatic bus_read(logic h, logic [11:0] exp_d, logic [11:0] exp_oe, string req);
    hb = h; cs_n = 1'b0; rd_n = 1'b0;
    tick(6);
    expect_item({req, " data"}, {20'h0, exp_d});   monitor_pop({20'h0, dout});
    expect_item({req, " enable"}, {20'h0, exp_oe}); monitor_pop({20'h0, doe});
    cs_n = 1'b1; rd_n = 1'b1;
    tick(16);
    expect_item("R4 release", 32'h0); monitor_pop({20'h0, doe});
  endtask

  initial begin
    tick(3);
    expect_item("R1 enables", 32'h0);    monitor_pop({20'h0, doe});
    expect_item("R1 ctrl", 32'h0);       monitor_pop({16'h0, ctrl});
    expect_item("R1 test", 32'h4002);    monitor_pop({16'h0, test});
    expect_item("R1 busy", 32'h0);       monitor_pop({31'h0, busy_out});
    rst_n = 1'b1;
    tick(3);

    // R2 R3: reads of two results
    load_result(12'hA5C);
    bus_read(1'b0, 12'hA5C, 12'hFFF, "R2 low read");
    bus_read(1'b1, 12'h00A, 12'h0FF, "R3 high read");
    load_result(12'h3F1);
    bus_read(1'b0, 12'h3F1, 12'hFFF, "R2 low read 2");
    bus_read(1'b1, 12'h003, 12'h0FF, "R3 high read 2");

    // R4: only one strobe low
    hb = 1'b0; cs_n = 1'b1; rd_n = 1'b0; tick(8);
    expect_item("R4 rd only", 32'h0); monitor_pop({20'h0, doe});
    cs_n = 1'b0; rd_n = 1'b1; tick(8);
    expect_item("R4 cs only", 32'h0); monitor_pop({20'h0, doe});
    cs_n = 1'b1; tick(4);

    // R5: low half alone commits nothing
    bus_write(1'b0, 8'h34);
    expect_item("R5 low half ctrl", 32'h0);    monitor_pop({16'h0, ctrl});
    expect_item("R5 low half test", 32'h4002); monitor_pop({16'h0, test});
    // R7: unchanged while strobe still low
    hb = 1'b1; din = 8'h12; cs_n = 1'b0; wr_n = 1'b0;
    tick(6);
    expect_item("R7 mid strobe", 32'h0); monitor_pop({16'h0, ctrl});
    cs_n = 1'b1; wr_n = 1'b1; tick(6);
    expect_item("R5 R6 ctrl word", 32'h1234); monitor_pop({16'h0, ctrl});
    expect_item("R6 test kept", 32'h4002);    monitor_pop({16'h0, test});

    // R6: word with top bits 01 goes to test register
    bus_write(1'b0, 8'hBC);
    bus_write(1'b1, 8'h4A);
    expect_item("R6 test word", 32'h4ABC); monitor_pop({16'h0, test});
    expect_item("R6 ctrl kept", 32'h1234); monitor_pop({16'h0, ctrl});

    // R10: restore default
    bus_write(1'b0, 8'h02);
    bus_write(1'b1, 8'h40);
    expect_item("R10 restore", 32'h4002); monitor_pop({16'h0, test});
    expect_item("R10 ctrl kept", 32'h1234); monitor_pop({16'h0, ctrl});

    // R8 R9: free-running mode
    hb = 1'b0; cs_n = 1'b0; rd_n = 1'b0;
    tick(6);
    busy = 1'b1; tick(4);
    expect_item("R9 busy out high", 32'h1); monitor_pop({31'h0, busy_out});
    res = 12'h7E5; res_vld = 1'b1; tick(1); res_vld = 1'b0;
    tick(5);
    expect_item("R8 old result kept", 32'h3F1); monitor_pop({20'h0, dout});
    busy = 1'b0; tick(2);
    expect_item("R9 busy lag", 32'h1); monitor_pop({31'h0, busy_out});
    tick(1);
    expect_item("R9 busy fell", 32'h0); monitor_pop({31'h0, busy_out});
    expect_item("R9 data at busy fall", 32'h7E5); monitor_pop({20'h0, dout});
    expect_item("R9 lines driven", 32'hFFF); monitor_pop({20'h0, doe});
    cs_n = 1'b1; rd_n = 1'b1; tick(16);
    expect_item("R4 release free-run", 32'h0); monitor_pop({20'h0, doe});

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule